// File: doc/BRIEF.md
# Shared Stream Buffer Arbiter

This block shares one small word-wide buffer memory (32 words of 32 bits) between two masters: the processor's system bus and a GPIO streaming engine. While the engine reports that an automatic stream is running, it alone drives the memory, reading out or filling in stream words at word indices it chooses. When the engine is idle, the processor can read and write the buffer through a 128-byte address window at byte offsets 0x80 to 0xFF.

The block decodes the bus address window, chooses which master drives the memory's index, write data and write strobe, and returns the memory's read data to both sides with a qualifier for each. A bus access that falls in the window while the engine is busy is held off and not dropped: the bus master keeps its request raised, and the access completes once the engine goes idle. The memory is a synchronous RAM with one cycle of read latency. It is written so that block RAM can be inferred.

Top module: `stream_buf_arb`

## Requirements
- R1: In the clock cycle after a cycle with `rst` high, `bus_ack` and `eng_rvalid` are both low.
- R2: A bus write (`bus_we`=1) with `bus_addr` in 0x80..0xFF, made while `eng_busy` is low, stores all 32 bits of `bus_wdata` at word index `bus_addr[6:2]`. Bits [1:0] of the address have no effect. `bus_ack` is high in the cycle after the access is accepted.
- R3: A bus read (`bus_we`=0) in the window, made while the engine is idle, raises `bus_ack` in the cycle after acceptance, and `bus_rdata` holds the stored word in that same cycle. `bus_ack` stays high for exactly one cycle for each access, and no new access is accepted in a cycle where `bus_ack` is high.
- R4: A bus request whose address is outside 0x80..0xFF is never acknowledged and does not change the buffer.
- R5: While `eng_busy` is high, no bus access is accepted and `bus_ack` stays low. A request that is held across the busy period is accepted in the first cycle with `eng_busy` low.
- R6: If `eng_busy` rises in the same cycle that a bus request for the window arrives, the engine's access in that cycle is served and the bus access waits as in R5.
- R7: An engine read (`eng_busy`=1, `eng_req`=1, `eng_we`=0) raises `eng_rvalid` in the next cycle, and `eng_rdata` then holds the word at `eng_idx`.
- R8: An engine write (`eng_busy`=1, `eng_req`=1, `eng_we`=1) stores `eng_wdata` at `eng_idx`. A later bus read can see that word.
- R9: Engine requests made while `eng_busy` is low have no effect: `eng_rvalid` stays low and the buffer is not written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | 1 | Bus cycle request, held until acknowledged |
| bus_we | input | 1 | Bus write (1) or read (0) |
| bus_addr | input | 32 | Bus byte address |
| bus_wdata | input | 32 | Bus write data |
| bus_ack | output | 1 | One-cycle acknowledge for an access to the window |
| bus_rdata | output | 32 | Read data, valid while bus_ack is high after a read |
| eng_busy | input | 1 | Streaming engine is running and owns the buffer |
| eng_req | input | 1 | Engine access strobe for this cycle |
| eng_we | input | 1 | Engine write (1) or read (0) |
| eng_idx | input | 5 | Engine word index |
| eng_wdata | input | 32 | Engine write data |
| eng_rvalid | output | 1 | Engine read data valid |
| eng_rdata | output | 32 | Engine read data |

## Verification
An engine access and a bus access can fall in the same cycle. That happens when `eng_busy` rises in the cycle a bus request for the window appears, and also throughout a busy period while the bus master keeps its request raised. The bench provokes this by raising `eng_busy` together with an engine write to word 3 and a bus read of the same word. It keeps the engine busy for several cycles of writes and reads, then releases it. The bench judges the outcome in three ways: `bus_ack` must stay low for the whole busy period, the engine's data must come back on `eng_rdata`, and the delayed bus read must return the word the engine wrote, not the older bus value.

// File: rtl/stream_buf_pkg.sv
package stream_buf_pkg;
  typedef enum logic {
    OWNER_BUS = 1'b0,
    OWNER_ENG = 1'b1
  } owner_e;
endpackage

// File: rtl/sbuf_decode.sv
module sbuf_decode #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 32,
  parameter logic [ADDR_W-1:0] BASE = 'h80
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [$clog2(WORDS)-1:0] idx
);
  localparam int BYTE_LSB = $clog2(DATA_W / 8);
  localparam int IDX_W    = $clog2(WORDS);
  localparam int WIN_LSB  = BYTE_LSB + IDX_W;

  logic unused_lanes;
  assign unused_lanes = ^addr[BYTE_LSB-1:0];

  always_comb begin
    hit = req && (addr[ADDR_W-1:WIN_LSB] == BASE[ADDR_W-1:WIN_LSB]);
    idx = addr[WIN_LSB-1:BYTE_LSB];
  end
endmodule

// File: rtl/sbuf_port_mux.sv
module sbuf_port_mux
  import stream_buf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              eng_busy,
  input  logic              eng_req,
  input  logic              eng_we,
  input  logic [IDX_W-1:0]  eng_idx,
  input  logic [DATA_W-1:0] eng_wdata,
  input  logic              bus_go,
  input  logic              bus_we,
  input  logic [IDX_W-1:0]  bus_idx,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [IDX_W-1:0]  mem_idx,
  output logic [DATA_W-1:0] mem_wdata
);
  owner_e owner;

  always_comb begin
    owner = eng_busy ? OWNER_ENG : OWNER_BUS;
    if (owner == OWNER_ENG) begin
      mem_en    = eng_req;
      mem_we    = eng_req && eng_we;
      mem_idx   = eng_idx;
      mem_wdata = eng_wdata;
    end else begin
      mem_en    = bus_go;
      mem_we    = bus_go && bus_we;
      mem_idx   = bus_idx;
      mem_wdata = bus_wdata;
    end
  end
endmodule

// File: rtl/sbuf_ram.sv
module sbuf_ram #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 32,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[idx] <= wdata;
      rdata <= mem[idx];
    end
  end
endmodule

// File: rtl/stream_buf_arb.sv
module stream_buf_arb #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 32,
  parameter logic [ADDR_W-1:0] BASE = 'h80,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ack,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              eng_busy,
  input  logic              eng_req,
  input  logic              eng_we,
  input  logic [IDX_W-1:0]  eng_idx,
  input  logic [DATA_W-1:0] eng_wdata,
  output logic              eng_rvalid,
  output logic [DATA_W-1:0] eng_rdata
);
  logic              bus_hit;
  logic [IDX_W-1:0]  bus_idx;
  logic              bus_go;
  logic              mem_en, mem_we;
  logic [IDX_W-1:0]  mem_idx;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;

  sbuf_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .BASE(BASE)) u_dec (
    .req(bus_req), .addr(bus_addr), .hit(bus_hit), .idx(bus_idx)
  );

  // Bus is served only when the engine is idle and no ack is in flight.
  assign bus_go = bus_hit && !eng_busy && !bus_ack;

  sbuf_port_mux #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mux (
    .eng_busy(eng_busy), .eng_req(eng_req), .eng_we(eng_we),
    .eng_idx(eng_idx), .eng_wdata(eng_wdata),
    .bus_go(bus_go), .bus_we(bus_we), .bus_idx(bus_idx), .bus_wdata(bus_wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_idx(mem_idx), .mem_wdata(mem_wdata)
  );

  sbuf_ram #(.DATA_W(DATA_W), .WORDS(WORDS)) u_ram (
    .clk(clk), .en(mem_en), .we(mem_we), .idx(mem_idx),
    .wdata(mem_wdata), .rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack    <= 1'b0;
      eng_rvalid <= 1'b0;
    end else begin
      bus_ack    <= bus_go;
      eng_rvalid <= eng_busy && eng_req && !eng_we;
    end
  end

  assign bus_rdata = mem_rdata;
  assign eng_rdata = mem_rdata;
endmodule

// File: rtl/sbuf_arb_chk.sv
module sbuf_arb_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 32,
  parameter logic [ADDR_W-1:0] BASE = 'h80
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ack,
  input logic              eng_busy,
  input logic              eng_req,
  input logic              eng_we,
  input logic              eng_rvalid
);
  localparam logic [ADDR_W:0] WIN_END = {1'b0, BASE} + (WORDS * DATA_W / 8);

  logic in_win;
  assign in_win = ({1'b0, bus_addr} >= {1'b0, BASE}) && ({1'b0, bus_addr} < WIN_END);

  logic unused_we;
  assign unused_we = bus_we;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!bus_ack && !eng_rvalid));

  // R2
  accept_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && in_win && !eng_busy && !bus_ack) |=> bus_ack);

  // R3
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);

  // R4
  ack_needs_window_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> $past(bus_req && in_win));

  // R5
  busy_lockout_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> $past(!eng_busy));

  // R7
  eng_read_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_busy && eng_req && !eng_we) |=> eng_rvalid);

  // R9
  eng_idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    eng_rvalid |-> $past(eng_busy && eng_req && !eng_we));
endmodule

bind stream_buf_arb sbuf_arb_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .BASE(BASE)
) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_ack(bus_ack), .eng_busy(eng_busy), .eng_req(eng_req), .eng_we(eng_we),
  .eng_rvalid(eng_rvalid)
);

// File: tb/sim_stream_buf_arb.sv
`timescale 1ns/1ps
module sim_stream_buf_arb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic        bus_ack;
  logic [31:0] bus_rdata;
  logic        eng_busy = 1'b0, eng_req = 1'b0, eng_we = 1'b0;
  logic [4:0]  eng_idx = '0;
  logic [31:0] eng_wdata = '0;
  logic        eng_rvalid;
  logic [31:0] eng_rdata;

  always #2 clk = ~clk;

  stream_buf_arb u0 (
    .clk(clk), .rst(rst),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .eng_busy(eng_busy), .eng_req(eng_req), .eng_we(eng_we), .eng_idx(eng_idx),
    .eng_wdata(eng_wdata), .eng_rvalid(eng_rvalid), .eng_rdata(eng_rdata)
  );

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [31:0] m_mem [32];
  bit          m_ack = 0, m_ackrd = 0, m_rv = 0;
  logic [31:0] m_bdata, m_edata;

  always @(posedge clk) begin
    bit n_ack, n_rv;
    n_ack = 0; n_rv = 0;
    if (!rst) begin
      if (eng_busy) begin
        if (eng_req) begin
          if (eng_we) m_mem[eng_idx] = eng_wdata;
          else begin m_edata = m_mem[eng_idx]; n_rv = 1; end
        end
      end else if (bus_req && bus_addr >= 32'h80 && bus_addr <= 32'hFF && !m_ack) begin
        n_ack  = 1;
        m_ackrd = !bus_we;
        if (bus_we) m_mem[bus_addr[6:2]] = bus_wdata;
        else m_bdata = m_mem[bus_addr[6:2]];
      end
    end
    m_ack = n_ack;
    m_rv  = n_rv;
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(bus_ack === m_ack, {cur_req, " bus_ack"}, {31'd0, bus_ack}, {31'd0, m_ack});
      if (m_ack && m_ackrd)
        chk(bus_rdata === m_bdata, {cur_req, " bus_rdata"}, bus_rdata, m_bdata);
      chk(eng_rvalid === m_rv, {cur_req, " eng_rvalid"}, {31'd0, eng_rvalid}, {31'd0, m_rv});
      if (m_rv)
        chk(eng_rdata === m_edata, {cur_req, " eng_rdata"}, eng_rdata, m_edata);
    end
  end

  task automatic bus_txn(input bit we, input logic [31:0] addr, input logic [31:0] d,
                         output logic [31:0] rd);
    int n = 0;
    bus_req = 1; bus_we = we; bus_addr = addr; bus_wdata = d;
    @(negedge clk);
    while (!bus_ack && n < 50) begin n++; @(negedge clk); end
    chk(bus_ack === 1'b1, {cur_req, " ack arrives"}, {31'd0, bus_ack}, 32'd1);
    rd = bus_rdata;
    bus_req = 0;
    @(negedge clk);
    chk(bus_ack === 1'b0, "R3 ack single cycle", {31'd0, bus_ack}, 32'd0);
  endtask

  initial begin
    logic [31:0] rd;
    int waited;
    repeat (3) @(negedge clk);
    chk(bus_ack === 1'b0 && eng_rvalid === 1'b0, "R1 reset outputs", {30'd0, bus_ack, eng_rvalid}, 32'd0);
    rst = 0;
    @(negedge clk);
    chk(bus_ack === 1'b0 && eng_rvalid === 1'b0, "R1 after reset", {30'd0, bus_ack, eng_rvalid}, 32'd0);

    // Fill the buffer; low address bits vary and must be ignored
    cur_req = "R2";
    for (int i = 0; i < 32; i++)
      bus_txn(1, 32'h80 + 4 * i + (i % 4), 32'hC0DE_0000 + i, rd);

    cur_req = "R3";
    bus_txn(0, 32'h80, 0, rd);        chk(rd === 32'hC0DE_0000, "R3 read word 0", rd, 32'hC0DE_0000);
    bus_txn(0, 32'hFD, 0, rd);        chk(rd === 32'hC0DE_001F, "R3 read word 31", rd, 32'hC0DE_001F);
    bus_txn(0, 32'h96, 0, rd);        chk(rd === 32'hC0DE_0005, "R2 lanes ignored", rd, 32'hC0DE_0005);

    // Outside the window
    cur_req = "R4";
    foreach (bus_addr[k]) begin end
    for (int j = 0; j < 3; j++) begin
      bus_req = 1; bus_we = 1; bus_wdata = 32'hDEAD_BEEF;
      bus_addr = (j == 0) ? 32'h7C : (j == 1) ? 32'h100 : 32'h0;
      repeat (4) begin
        @(negedge clk);
        chk(bus_ack === 1'b0, "R4 no ack outside window", {31'd0, bus_ack}, 32'd0);
      end
      bus_req = 0;
    end
    bus_txn(0, 32'h80, 0, rd);        chk(rd === 32'hC0DE_0000, "R4 word 0 intact", rd, 32'hC0DE_0000);
    bus_txn(0, 32'h84, 0, rd);        chk(rd === 32'hC0DE_0001, "R4 word 1 intact", rd, 32'hC0DE_0001);

    // Collision: busy rises with an engine write and a bus read together
    cur_req = "R6";
    eng_busy = 1; eng_req = 1; eng_we = 1; eng_idx = 3; eng_wdata = 32'hE0E0_0003;
    bus_req = 1; bus_we = 0; bus_addr = 32'h8C;
    @(negedge clk);
    chk(bus_ack === 1'b0, "R6 engine wins", {31'd0, bus_ack}, 32'd0);
    cur_req = "R8";
    eng_idx = 4; eng_wdata = 32'hE0E0_0004;
    @(negedge clk);
    chk(bus_ack === 1'b0, "R5 locked out", {31'd0, bus_ack}, 32'd0);
    cur_req = "R7";
    eng_we = 0; eng_idx = 3;
    @(negedge clk);
    chk(eng_rvalid === 1'b1 && eng_rdata === 32'hE0E0_0003, "R7 engine read", eng_rdata, 32'hE0E0_0003);
    eng_req = 0;
    cur_req = "R5";
    repeat (2) begin
      @(negedge clk);
      chk(bus_ack === 1'b0, "R5 locked out", {31'd0, bus_ack}, 32'd0);
    end
    eng_busy = 0;
    waited = 0;
    @(negedge clk);
    while (!bus_ack && waited < 50) begin waited++; @(negedge clk); end
    chk(waited == 0, "R5 ack right after idle", waited, 0);
    chk(bus_rdata === 32'hE0E0_0003, "R6 bus sees engine word", bus_rdata, 32'hE0E0_0003);
    bus_req = 0;
    @(negedge clk);
    cur_req = "R8";
    bus_txn(0, 32'h90, 0, rd);        chk(rd === 32'hE0E0_0004, "R8 engine write stored", rd, 32'hE0E0_0004);

    // Engine requests while idle
    cur_req = "R9";
    eng_req = 1; eng_we = 1; eng_idx = 5; eng_wdata = 32'hBAD0_0005;
    @(negedge clk);
    eng_we = 0;
    @(negedge clk);
    chk(eng_rvalid === 1'b0, "R9 no rvalid when idle", {31'd0, eng_rvalid}, 32'd0);
    eng_req = 0;
    @(negedge clk);
    chk(eng_rvalid === 1'b0, "R9 no rvalid when idle", {31'd0, eng_rvalid}, 32'd0);
    bus_txn(0, 32'h94, 0, rd);        chk(rd === 32'hC0DE_0005, "R9 word 5 unchanged", rd, 32'hC0DE_0005);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule